// File: doc/BRIEF.md
# DDR2 Mode Register Load Unit

This unit sits on the controller side of a DDR2 interface. It keeps a copy of the main mode register and turns a load request into a single-cycle mode-load command on the bank-address and address pins. Each request carries a complete register word and a two-bit target select. The select picks the main register or one of the three extended registers. Every field is rewritten on each load. A field that changes alone still needs the full word.

A request goes out only when every bank reports idle, no burst is running, and no earlier load is still in its settle window. A request for the main register must also hold only legal codes for burst length, CAS latency and write recovery. Any request that fails these checks gets a one-cycle error pulse and changes nothing. After each command the unit holds a busy output high for a fixed number of cycles, so the rest of the controller cannot issue a following command too soon. The stored main-register image is decoded into plain fields for the rest of the controller. Its DLL-reset bit always reads back as zero, because that bit clears itself once the command has gone out.

Top module: `ddr2_mode_load`

## Requirements
- R1: A request sampled on a clock edge with `req_valid` high and all gates open produces `cmd_load` high for exactly the next cycle. In that cycle `cmd_addr` equals the requested word, `cmd_ba[1:0]` equals `req_sel`, and the upper bank-address bits are 0. When no command is issued, `cmd_load`, `cmd_ba` and `cmd_addr` are all zero.
- R2: Burst length is held in bits 2:0. Code 3'b010 means 4 beats (`bl8`=0) and code 3'b011 means 8 beats (`bl8`=1). Any other code in a main-register request is refused.
- R3: Bit 3 selects the burst order: 0 is sequential and 1 is interleaved. It is reported on `interleave`.
- R4: CAS latency is held in bits 6:4. Codes 2 to 6 give that latency on `cas_lat`. Codes 0, 1 and 7 in a main-register request are refused.
- R5: Bit 7 selects test operation and is reported on `test_mode`. Bit 12 selects slow power-down exit and is reported on `pd_slow`.
- R6: Bit 8, the DLL reset, is driven on `cmd_addr` as requested. In the stored image it always reads back as 0.
- R7: Write recovery is held in bits 11:9. Codes 1 to 7 give 2 to 8 cycles on `wr_rec`. Code 0 in a main-register request is refused.
- R8: A request made while `banks_idle` is low or `burst_active` is high is refused. A refusal raises `req_err` for exactly the next cycle, issues no command and leaves `mr_image` unchanged.
- R9: `busy` is high for exactly TMRD cycles (default 2), starting in the cycle after the command cycle. Requests sampled during the command cycle or while `busy` is high are refused.
- R10: Requests with `req_sel` not 0 target an extended register. They issue the command without any encoding check and leave `mr_image` unchanged.
- R11: After reset, `mr_image` is 0x0232 (4 beats, sequential, CAS latency 3, write recovery 2). `busy`, `cmd_load` and `req_err` are all low.
- R12: An accepted main-register load replaces every field of `mr_image` with the new word, apart from the cleared DLL-reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request strobe |
| req_sel | input | 2 | Target register: 0 main, 1 to 3 extended |
| req_value | input | ADDR_W | Full register word to load |
| banks_idle | input | 1 | All banks precharged |
| burst_active | input | 1 | A read or write burst is in progress |
| cmd_load | output | 1 | Mode-load command cycle |
| cmd_ba | output | BA_W | Bank-address pins for the command |
| cmd_addr | output | ADDR_W | Address pins for the command |
| busy | output | 1 | Settle window; no other command may issue |
| req_err | output | 1 | One-cycle refusal pulse |
| mr_image | output | ADDR_W | Stored main-register word |
| bl8 | output | 1 | 1 for 8-beat bursts, 0 for 4-beat bursts |
| interleave | output | 1 | Interleaved burst order |
| cas_lat | output | 3 | CAS latency in cycles |
| test_mode | output | 1 | Test operation selected |
| wr_rec | output | 4 | Write recovery in cycles |
| pd_slow | output | 1 | Slow (low-power) power-down exit |

## Verification
The bench sends each reserved code to the main register in turn: burst-length codes 0 and 7, CAS latency codes 0, 1 and 7, and write recovery code 0. A design that screened too few codes would issue a command and overwrite the image. The same bit patterns are also sent to an extended register, where they must pass unchecked; a design that screened every target would refuse them. The bench makes requests in the command cycle itself and inside the settle window, and it measures the exact length of `busy`; an off-by-one counter or a missing gate shows up as an accepted command or a wrong busy count. A load with the DLL-reset bit set, followed by a load that clears several fields at once, catches an image that keeps the DLL-reset bit or updates fields only in part.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    // Target register select carried on the two low bank-address bits
    typedef enum logic [1:0] {
        SEL_MAIN = 2'b00,
        SEL_EXT1 = 2'b01,
        SEL_EXT2 = 2'b10,
        SEL_EXT3 = 2'b11
    } reg_sel_e;

    // Field positions in the main register word
    localparam int BL_LSB   = 0;
    localparam int BT_BIT   = 3;
    localparam int CL_LSB   = 4;
    localparam int TM_BIT   = 7;
    localparam int DLL_BIT  = 8;
    localparam int WR_LSB   = 9;
    localparam int PD_BIT   = 12;
    localparam int FIELD_MSB = 12;

    // Legal burst-length codes
    localparam logic [2:0] BL_CODE_4 = 3'b010;
    localparam logic [2:0] BL_CODE_8 = 3'b011;

    // Legal CAS latency code range
    localparam logic [2:0] CL_CODE_MIN = 3'd2;
    localparam logic [2:0] CL_CODE_MAX = 3'd6;

endpackage

// File: rtl/mrs_code_screen.sv
module mrs_code_screen
    import mrs_pkg::*;
(
    input  logic [2:0] bl_code,
    input  logic [2:0] cl_code,
    input  logic [2:0] wr_code,
    output logic       bl_bad,
    output logic       cl_bad,
    output logic       wr_bad
);

    always_comb begin
        bl_bad = (bl_code != BL_CODE_4) && (bl_code != BL_CODE_8);
        cl_bad = (cl_code < CL_CODE_MIN) || (cl_code > CL_CODE_MAX);
        wr_bad = (wr_code == 3'd0);
    end

endmodule

// File: rtl/mrs_tmrd_lock.sv
module mrs_tmrd_lock #(
    parameter int TMRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = (TMRD < 1) ? 1 : $clog2(TMRD + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TMRD);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/ddr2_mode_load.sv
module ddr2_mode_load
    import mrs_pkg::*;
#(
    parameter int          ADDR_W     = 14,
    parameter int          BA_W       = 3,
    parameter int          TMRD       = 2,
    parameter logic [12:0] RST_FIELDS = 13'h0232
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_sel,
    input  logic [ADDR_W-1:0] req_value,
    input  logic              banks_idle,
    input  logic              burst_active,
    output logic              cmd_load,
    output logic [BA_W-1:0]   cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              req_err,
    output logic [ADDR_W-1:0] mr_image,
    output logic              bl8,
    output logic              interleave,
    output logic [2:0]        cas_lat,
    output logic              test_mode,
    output logic [3:0]        wr_rec,
    output logic              pd_slow
);

    localparam int BA_HI_W = BA_W - 2;
    localparam logic [ADDR_W-1:0] RST_IMAGE = ADDR_W'(RST_FIELDS);

    typedef struct packed {
        logic              load;
        logic              err;
        logic [1:0]        ba_lo;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] image;
    } state_t;

    state_t s_d, s_q;

    logic bl_bad, cl_bad, wr_bad;
    logic enc_bad, gate_ok;
    logic lock_busy;

    // Encoding screen on the incoming word
    mrs_code_screen u_screen (
        .bl_code (req_value[BL_LSB+2:BL_LSB]),
        .cl_code (req_value[CL_LSB+2:CL_LSB]),
        .wr_code (req_value[WR_LSB+2:WR_LSB]),
        .bl_bad  (bl_bad),
        .cl_bad  (cl_bad),
        .wr_bad  (wr_bad)
    );

    // Settle-window counter, started by the command cycle
    mrs_tmrd_lock #(
        .TMRD (TMRD)
    ) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .start (s_q.load),
        .busy  (lock_busy)
    );

    always_comb begin
        s_d       = s_q;
        s_d.load  = 1'b0;
        s_d.err   = 1'b0;
        s_d.ba_lo = 2'b00;
        s_d.addr  = '0;

        enc_bad = (reg_sel_e'(req_sel) == SEL_MAIN) && (bl_bad || cl_bad || wr_bad);
        gate_ok = banks_idle && !burst_active && !s_q.load && !lock_busy;

        if (req_valid) begin
            if (gate_ok && !enc_bad) begin
                s_d.load  = 1'b1;
                s_d.ba_lo = req_sel;
                s_d.addr  = req_value;
                if (reg_sel_e'(req_sel) == SEL_MAIN) begin
                    s_d.image          = req_value;
                    s_d.image[DLL_BIT] = 1'b0;
                end
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.load  <= 1'b0;
            s_q.err   <= 1'b0;
            s_q.ba_lo <= 2'b00;
            s_q.addr  <= '0;
            s_q.image <= RST_IMAGE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_load = s_q.load;
    assign cmd_ba   = {{BA_HI_W{1'b0}}, s_q.ba_lo};
    assign cmd_addr = s_q.addr;
    assign busy     = lock_busy;
    assign req_err  = s_q.err;
    assign mr_image = s_q.image;

    // Decoded view of the stored word
    assign bl8        = (s_q.image[BL_LSB+2:BL_LSB] == BL_CODE_8);
    assign interleave = s_q.image[BT_BIT];
    assign cas_lat    = s_q.image[CL_LSB+2:CL_LSB];
    assign test_mode  = s_q.image[TM_BIT];
    assign wr_rec     = {1'b0, s_q.image[WR_LSB+2:WR_LSB]} + 4'd1;
    assign pd_slow    = s_q.image[PD_BIT];

endmodule

// File: rtl/mrs_load_chk.sv
module mrs_load_chk #(
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3,
    parameter int TMRD   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_load,
    input logic [BA_W-1:0]   cmd_ba,
    input logic              busy,
    input logic              req_err,
    input logic [ADDR_W-1:0] mr_image
);

    int run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    // R1
    ba_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |-> (cmd_ba[BA_W-1:2] == '0));

    // R9
    no_cmd_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_load);

    // R9
    lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |=> busy);

    // R9
    lock_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= TMRD);

    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_load && req_err));

    // R8
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (mr_image == $past(mr_image)));

    // R6
    dll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mr_image[8] == 1'b0);

    // R10
    ext_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && cmd_ba[1:0] != 2'b00) |-> (mr_image == $past(mr_image)));

    // R2
    bl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_image[2:0] == 3'b010) || (mr_image[2:0] == 3'b011));

endmodule

bind ddr2_mode_load mrs_load_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .TMRD   (TMRD)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_load (cmd_load),
    .cmd_ba   (cmd_ba),
    .busy     (busy),
    .req_err  (req_err),
    .mr_image (mr_image)
);

// File: tb/sim_ddr2_mode_load.sv
module sim_ddr2_mode_load;

    localparam int ADDR_W = 14;
    localparam int BA_W   = 3;
    localparam int TMRD   = 2;
    localparam int NVEC   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_sel = 2'b00;
    logic [ADDR_W-1:0] req_value = '0;
    logic              banks_idle = 1'b1;
    logic              burst_active = 1'b0;
    logic              cmd_load;
    logic [BA_W-1:0]   cmd_ba;
    logic [ADDR_W-1:0] cmd_addr;
    logic              busy;
    logic              req_err;
    logic [ADDR_W-1:0] mr_image;
    logic              bl8;
    logic              interleave;
    logic [2:0]        cas_lat;
    logic              test_mode;
    logic [3:0]        wr_rec;
    logic              pd_slow;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [ADDR_W-1:0] model_img = 14'h0232;

    always #5 clk = ~clk;

    ddr2_mode_load #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .TMRD   (TMRD)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_sel      (req_sel),
        .req_value    (req_value),
        .banks_idle   (banks_idle),
        .burst_active (burst_active),
        .cmd_load     (cmd_load),
        .cmd_ba       (cmd_ba),
        .cmd_addr     (cmd_addr),
        .busy         (busy),
        .req_err      (req_err),
        .mr_image     (mr_image),
        .bl8          (bl8),
        .interleave   (interleave),
        .cas_lat      (cas_lat),
        .test_mode    (test_mode),
        .wr_rec       (wr_rec),
        .pd_slow      (pd_slow)
    );

    // Vector: {sel[1:0], value[13:0], idle, burst, expect_accept}
    localparam logic [18:0] VEC [NVEC] = '{
        {2'd0, 14'h0232, 1'b1, 1'b0, 1'b1},
        {2'd0, 14'h1B5B, 1'b1, 1'b0, 1'b1},
        {2'd0, 14'h0EA2, 1'b1, 1'b0, 1'b1},
        {2'd0, 14'h0263, 1'b1, 1'b0, 1'b1},
        {2'd0, 14'h0230, 1'b1, 1'b0, 1'b0},
        {2'd0, 14'h0237, 1'b1, 1'b0, 1'b0},
        {2'd0, 14'h0202, 1'b1, 1'b0, 1'b0},
        {2'd0, 14'h0212, 1'b1, 1'b0, 1'b0},
        {2'd0, 14'h0272, 1'b1, 1'b0, 1'b0},
        {2'd0, 14'h0032, 1'b1, 1'b0, 1'b0},
        {2'd0, 14'h0243, 1'b0, 1'b0, 1'b0},
        {2'd0, 14'h0243, 1'b1, 1'b1, 1'b0},
        {2'd1, 14'h0000, 1'b1, 1'b0, 1'b1},
        {2'd3, 14'h0077, 1'b1, 1'b0, 1'b1},
        {2'd0, 14'h0243, 1'b1, 1'b0, 1'b1},
        {2'd2, 14'h1FFF, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_fields(input string ctx);
        chk({ctx, " R12 image"}, 32'(mr_image), 32'(model_img));
        chk({ctx, " R2 bl8"}, 32'(bl8), 32'(model_img[2:0] == 3'b011));
        chk({ctx, " R3 interleave"}, 32'(interleave), 32'(model_img[3]));
        chk({ctx, " R4 cas_lat"}, 32'(cas_lat), 32'(model_img[6:4]));
        chk({ctx, " R5 test_mode"}, 32'(test_mode), 32'(model_img[7]));
        chk({ctx, " R5 pd_slow"}, 32'(pd_slow), 32'(model_img[12]));
        chk({ctx, " R7 wr_rec"}, 32'(wr_rec), 32'(model_img[11:9]) + 32'd1);
    endtask

    // Drive at a negedge, hold across one posedge, release at the next negedge
    task automatic send(input logic [1:0] sel, input logic [ADDR_W-1:0] val);
        req_sel   = sel;
        req_value = val;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int busy_run;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 image", 32'(mr_image), 32'h0232);
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R11 cmd_load", 32'(cmd_load), 32'd0);
        chk("R11 req_err", 32'(req_err), 32'd0);
        chk("R11 cas_lat", 32'(cas_lat), 32'd3);
        chk("R11 wr_rec", 32'(wr_rec), 32'd2);
        chk("R11 bl8", 32'(bl8), 32'd0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]        sel;
            logic [ADDR_W-1:0] val;
            logic              ok;
            sel          = VEC[v][18:17];
            val          = VEC[v][16:3];
            banks_idle   = VEC[v][2];
            burst_active = VEC[v][1];
            ok           = VEC[v][0];
            send(sel, val);
            banks_idle   = 1'b1;
            burst_active = 1'b0;
            if (ok && sel == 2'd0) begin
                model_img    = val;
                model_img[8] = 1'b0;
            end
            chk($sformatf("R1 vec%0d cmd_load", v), 32'(cmd_load), 32'(ok));
            chk($sformatf("R8 vec%0d req_err", v), 32'(req_err), 32'(!ok));
            if (ok) begin
                chk($sformatf("R1 vec%0d cmd_addr", v), 32'(cmd_addr), 32'(val));
                chk($sformatf("R1 vec%0d cmd_ba", v), 32'(cmd_ba), 32'(sel));
                if (sel != 2'd0)
                    chk($sformatf("R10 vec%0d image kept", v), 32'(mr_image), 32'(model_img));
                if (val[8])
                    chk($sformatf("R6 vec%0d dll cleared", v), 32'(mr_image[8]), 32'd0);
            end else begin
                chk($sformatf("R1 vec%0d idle pins", v), 32'({cmd_ba, cmd_addr}), 32'd0);
            end
            check_fields($sformatf("vec%0d", v));
            @(negedge clk);
            chk($sformatf("R9 vec%0d busy", v), 32'(busy), 32'(ok));
            idle_wait(TMRD + 1);
        end

        // R9 lockout: request in the command cycle and inside the window
        send(2'd0, 14'h0A53);
        model_img = 14'h0A53;
        chk("R9 first accepted", 32'(cmd_load), 32'd1);
        send(2'd0, 14'h0243);
        chk("R9 cmd-cycle refused", 32'(req_err), 32'd1);
        chk("R9 cmd-cycle no cmd", 32'(cmd_load), 32'd0);
        chk("R9 busy after cmd", 32'(busy), 32'd1);
        send(2'd1, 14'h0000);
        chk("R9 window refused", 32'(req_err), 32'd1);
        chk("R9 window no cmd", 32'(cmd_load), 32'd0);
        check_fields("R9 lock");
        idle_wait(TMRD + 1);

        // R9 busy length
        send(2'd2, 14'h0001);
        busy_run = 0;
        for (int i = 0; i < TMRD + 4; i++) begin
            @(negedge clk);
            if (busy) busy_run++;
        end
        chk("R9 busy length", 32'(busy_run), 32'(TMRD));
        send(2'd0, 14'h0243);
        model_img = 14'h0243;
        chk("R9 accepted after window", 32'(cmd_load), 32'd1);
        check_fields("R9 after");
        idle_wait(TMRD + 1);

        // R6 DLL bit on pins, cleared in image
        send(2'd0, 14'h0333);
        model_img = 14'h0233;
        chk("R6 dll on pins", 32'(cmd_addr[8]), 32'd1);
        chk("R6 dll image", 32'(mr_image[8]), 32'd0);
        check_fields("R6");
        idle_wait(TMRD + 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule